// File: doc/BRIEF.md
# Seconds Watchdog with Keyboard-Reset Pulse

This block is a watchdog timer that counts down in whole seconds. Software arms it by writing a nonzero count to an 8-bit timeout register. Writing zero disarms it. Reading the same register returns the live number of seconds left. A prescaler divides the clock down to a one-second tick. The prescaler starts over whenever the timeout register is written, so each newly written count lasts its full length.

When the count steps from 1 to 0, the block does three things. It latches a timeout status flag. It leaves the counter parked at zero. It drives the active-low watchdog output low for a fixed number of clock cycles. A control bit can also send that low pulse onto an active-low keyboard-reset line.

Two enable bits let a keyboard event or a mouse event reload a running counter. The reload value is the last nonzero count that software wrote. The register interface is a plain single-cycle strobe and has no back-pressure. A write takes effect at the clock edge on which `reg_wr` is sampled high. The read data is combinational from `reg_sel`.

Top module: `sec_watchdog`

## Requirements
- R1: After reset, the count, control and trigger registers all read 0, and both `wdt_out_n` and `kbrst_n` are high.
- R2: A nonzero write with `reg_sel`=0 loads the count, remembers the value for reloads and restarts the prescaler. A read with `reg_sel`=0 returns the current count, including values up to 255.
- R3: While the count is nonzero, it drops by one every `CLK_HZ` clock cycles, counted from the write edge. A value N therefore expires exactly N·`CLK_HZ` cycles after the edge that wrote it. Writing a new value while running re-arms the counter from that write.
- R4: Writing 0 with `reg_sel`=0 stops the counter. It stays at 0 and no expiry follows.
- R5: On the 1-to-0 step, the count remains 0 and the status flag (bit 4 of the trigger register, `reg_sel`=2) is set.
- R6: At expiry, `wdt_out_n` goes low for exactly `PULSE_CYCLES` clock cycles, starting at the expiry edge.
- R7: While bit 1 of the control register (`reg_sel`=1) is set, `kbrst_n` follows `wdt_out_n`. While that bit is clear, `kbrst_n` stays high.
- R8: Bit 7 of the trigger register enables keyboard reload and bit 6 enables mouse reload. An enabled event pulse on a running counter reloads the last nonzero written value and restarts the prescaler.
- R9: An event whose enable bit is clear has no effect. An event also has no effect while the count is 0.
- R10: Writing 0 to trigger bit 4 clears the status flag, and writing 1 there does not set it. Trigger bits other than 7, 6 and 4 read as 0. The control register reads back as written. `reg_sel`=3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_sel | input | 2 | Register select: 0 count, 1 control, 2 trigger, 3 none |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| kbd_evt | input | 1 | Keyboard activity pulse |
| mouse_evt | input | 1 | Mouse activity pulse |
| wdt_out_n | output | 1 | Active-low watchdog expiry pulse |
| kbrst_n | output | 1 | Active-low keyboard-reset pulse |

## Verification
The bench places expiries on the exact cycle. A prescaler that keeps running across a write would fire up to one second early, and an off-by-one in the decrement would shift the pulse by a whole second. It checks that a mouse event with only keyboard reload enabled leaves the count alone, and that events on a stopped timer do not re-arm it; a design that got either wrong would expire without being asked to. It also writes 1 to the status bit while the flag is clear, which catches a flag that can be set from software, and it routes the pulse to the keyboard-reset line only when the control bit is set.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned REG_W = 8;

  typedef enum logic [1:0] {
    SEL_COUNT = 2'd0,
    SEL_CTRL  = 2'd1,
    SEL_TRIG  = 2'd2,
    SEL_NONE  = 2'd3
  } wdt_sel_e;

  localparam int unsigned CTRL_KBRST_BIT = 1;
  localparam int unsigned TRIG_STAT_BIT  = 4;
  localparam int unsigned TRIG_MOUSE_BIT = 6;
  localparam int unsigned TRIG_KBD_BIT   = 7;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned TICK_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned PW = (TICK_CYCLES < 2) ? 1 : $clog2(TICK_CYCLES);

  logic [PW-1:0] div_q;

  assign tick = (div_q == PW'(TICK_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              div_q <= '0;
    else if (restart || tick) div_q <= '0;
    else                     div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown import wdt_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [REG_W-1:0] load_val,
  input  logic             reload,
  input  logic             tick,
  output logic [REG_W-1:0] count,
  output logic             expire
);
  logic [REG_W-1:0] count_q;
  logic [REG_W-1:0] keep_q;

  assign count  = count_q;
  assign expire = tick && !load && !reload && (count_q == REG_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      keep_q  <= '0;
    end else if (load) begin
      count_q <= load_val;
      if (load_val != '0) keep_q <= load_val;
    end else if (reload) begin
      count_q <= keep_q;
    end else if (tick && count_q != '0) begin
      count_q <= count_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int unsigned PULSE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic active
);
  localparam int unsigned CW = $clog2(PULSE_CYCLES + 1);

  logic [CW-1:0] left_q;

  assign active = (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      left_q <= '0;
    else if (fire)   left_q <= CW'(PULSE_CYCLES);
    else if (active) left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/sec_watchdog.sv
module sec_watchdog import wdt_pkg::*; #(
  parameter int unsigned CLK_HZ       = 100_000_000,
  parameter int unsigned PULSE_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             kbd_evt,
  input  logic             mouse_evt,
  output logic             wdt_out_n,
  output logic             kbrst_n
);
  logic [REG_W-1:0] ctrl_q;
  logic             kbd_en_q, mouse_en_q, status_q;
  logic [REG_W-1:0] count_q;
  logic             tm_wr, reload_fire, tick, expire, pulse_on;

  assign tm_wr       = reg_wr && (reg_sel == SEL_COUNT);
  assign reload_fire = !tm_wr && (count_q != '0) &&
                       ((kbd_evt && kbd_en_q) || (mouse_evt && mouse_en_q));

  wdt_prescaler #(.TICK_CYCLES(CLK_HZ)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(tm_wr || reload_fire), .tick(tick)
  );

  wdt_countdown u_cnt (
    .clk(clk), .rst_n(rst_n), .load(tm_wr), .load_val(reg_wdata),
    .reload(reload_fire), .tick(tick), .count(count_q), .expire(expire)
  );

  wdt_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(expire), .active(pulse_on)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      kbd_en_q   <= 1'b0;
      mouse_en_q <= 1'b0;
      status_q   <= 1'b0;
    end else begin
      if (reg_wr && reg_sel == SEL_CTRL) ctrl_q <= reg_wdata;
      if (reg_wr && reg_sel == SEL_TRIG) begin
        kbd_en_q   <= reg_wdata[TRIG_KBD_BIT];
        mouse_en_q <= reg_wdata[TRIG_MOUSE_BIT];
      end
      if (expire)
        status_q <= 1'b1;
      else if (reg_wr && reg_sel == SEL_TRIG)
        status_q <= status_q & reg_wdata[TRIG_STAT_BIT];
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel)
      SEL_COUNT: reg_rdata = count_q;
      SEL_CTRL:  reg_rdata = ctrl_q;
      SEL_TRIG: begin
        reg_rdata[TRIG_KBD_BIT]   = kbd_en_q;
        reg_rdata[TRIG_MOUSE_BIT] = mouse_en_q;
        reg_rdata[TRIG_STAT_BIT]  = status_q;
      end
      default:   reg_rdata = '0;
    endcase
  end

  assign wdt_out_n = !pulse_on;
  assign kbrst_n   = !(pulse_on && ctrl_q[CTRL_KBRST_BIT]);
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker import wdt_pkg::*; (
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] count,
  input logic             status,
  input logic             tm_wr,
  input logic             reload_fire,
  input logic             wdt_out_n,
  input logic             kbrst_n
);
  // R4: a stopped counter stays stopped without a count write
  p_stop_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !tm_wr) |=> count == '0);

  // R3: without a write or reload the count never grows
  p_no_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tm_wr && !reload_fire) |=> count <= $past(count));

  // R3: at most one step per cycle
  p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tm_wr && !reload_fire && count != '0) |=>
      (count == $past(count) || count == $past(count) - 1'b1));

  // R5: the pulse starts only on a 1-to-0 step, with the flag set
  p_expire_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_out_n) |-> (count == '0 && $past(count) == REG_W'(1) && status));

  // R7: the keyboard-reset line never pulses on its own
  p_kbrst_inside_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !kbrst_n |-> !wdt_out_n);
endmodule

bind sec_watchdog wdt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .count(count_q), .status(status_q),
  .tm_wr(tm_wr), .reload_fire(reload_fire),
  .wdt_out_n(wdt_out_n), .kbrst_n(kbrst_n)
);

// File: tb/sec_watchdog_bench.sv
module sec_watchdog_bench;
  localparam int TICK  = 10;
  localparam int PULSE = 4;

  logic       clk = 0, rst_n = 0, reg_wr = 0, kbd_evt = 0, mouse_evt = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic       wdt_out_n, kbrst_n;

  int checks = 0, errors = 0, cyc = 0;
  int exp_cyc_q[$];
  bit exp_kb_q[$];

  sec_watchdog #(.CLK_HZ(TICK), .PULSE_CYCLES(PULSE)) u_sec_watchdog (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .kbd_evt(kbd_evt),
    .mouse_evt(mouse_evt), .wdt_out_n(wdt_out_n), .kbrst_n(kbrst_n)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  // writes the count; when push is set, queues the expected expiry
  task automatic arm(int n, bit push, bit kb);
    int c;
    @(negedge clk);
    c = cyc;
    reg_sel = 2'd0; reg_wdata = 8'(n); reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
    if (push) begin
      exp_cyc_q.push_back(c + 1 + n * TICK);
      exp_kb_q.push_back(kb);
    end
  endtask

  task automatic rd(logic [1:0] sel, int exp, string req);
    @(negedge clk);
    reg_sel = sel;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic evt(bit is_kbd, output int d);
    @(negedge clk);
    d = cyc;
    if (is_kbd) kbd_evt = 1; else mouse_evt = 1;
    @(negedge clk);
    kbd_evt = 0; mouse_evt = 0;
  endtask

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expected expiries, checks cycle, routing and width (R3 R6 R7)
  bit prev_n = 1;
  bit cur_kb = 0;
  int low_w = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!wdt_out_n) begin
        if (prev_n) begin
          if (exp_cyc_q.size() == 0) begin
            chk("R4 unexpected expiry", cyc, -1);
            cur_kb = 0;
          end else begin
            chk("R3 expiry cycle", cyc, exp_cyc_q.pop_front());
            cur_kb = exp_kb_q.pop_front();
          end
          low_w = 1;
        end else low_w++;
        chk("R7 kbrst routing", kbrst_n, !cur_kb);
      end else begin
        if (!prev_n) chk("R6 pulse width", low_w, PULSE);
        if (!kbrst_n) chk("R7 kbrst idle", kbrst_n, 1);
      end
      prev_n = wdt_out_n;
    end
  end

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(2'd0, 0, "R1 count");
    rd(2'd1, 0, "R1 ctrl");
    rd(2'd2, 0, "R1 trig");
    chk("R1 wdt_out_n", wdt_out_n, 1);
    chk("R1 kbrst_n", kbrst_n, 1);

    // R2 R3 basic countdown
    arm(3, 1, 0);
    rd(2'd0, 3, "R2 readback");
    waitc(10);
    rd(2'd0, 2, "R3 one tick");
    waitc(45);
    rd(2'd0, 0, "R5 parked at zero");
    rd(2'd2, 8'h10, "R5 status set");
    rd(2'd3, 0, "R10 unused select");

    // R10 status clear and no software set
    wr(2'd2, 8'h00);
    rd(2'd2, 8'h00, "R10 status cleared");
    wr(2'd2, 8'hFF);
    rd(2'd2, 8'hC0, "R10 write-1 no set");
    wr(2'd2, 8'h00);

    // R7 pulse to keyboard reset
    wr(2'd1, 8'h02);
    rd(2'd1, 8'h02, "R10 ctrl readback");
    arm(2, 1, 1);
    waitc(40);
    wr(2'd1, 8'h00);

    // R4 stop
    arm(5, 0, 0);
    waitc(15);
    wr(2'd0, 8'h00);
    rd(2'd0, 0, "R4 stopped");
    waitc(80);

    // R3 re-arm while running
    arm(4, 0, 0);
    waitc(25);
    arm(3, 1, 0);
    waitc(45);

    // R2 boundary value
    arm(255, 0, 0);
    rd(2'd0, 255, "R2 max value");
    waitc(10);
    rd(2'd0, 254, "R3 max step");
    wr(2'd0, 8'h00);

    // R8 keyboard reload, R9 mouse ignored
    wr(2'd2, 8'h80);
    arm(2, 0, 0);
    waitc(12);
    rd(2'd0, 1, "R3 before reload");
    evt(0, d);
    rd(2'd0, 1, "R9 mouse disabled");
    evt(1, d);
    exp_cyc_q.push_back(d + 1 + 2 * TICK);
    exp_kb_q.push_back(0);
    rd(2'd0, 2, "R8 kbd reload");
    waitc(40);

    // R8 mouse reload, R9 keyboard ignored
    wr(2'd2, 8'h40);
    arm(3, 0, 0);
    waitc(12);
    evt(1, d);
    rd(2'd0, 2, "R9 kbd disabled");
    evt(0, d);
    exp_cyc_q.push_back(d + 1 + 3 * TICK);
    exp_kb_q.push_back(0);
    rd(2'd0, 3, "R8 mouse reload");
    waitc(50);

    // R9 events on a stopped counter
    wr(2'd2, 8'hC0);
    evt(1, d);
    evt(0, d);
    rd(2'd0, 0, "R9 stopped no reload");
    waitc(40);

    chk("R3 all expiries seen", exp_cyc_q.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule